// File: doc/BRIEF.md
# One-Hot Dual-Pattern Serial Detector

This block watches a single serial data line, one bit per clock, and raises its output whenever the bit stream has just completed either of two five-bit words, 10111 or 11011 (leftmost bit received first). The same output is also raised whenever the three most recent bits, oldest first, were 1, 0, 1. Scanning never stops or restarts after a hit, so the tail of one occurrence may begin the next.

The machine is a Moore machine with one flip-flop per state and exactly one of them set at a time. Ten states track the longest recent stretch of input that could still grow into one of the two words. The output is an OR of the four states whose history ends in a completed word or in 1,0,1. The three-bit condition therefore needs no storage of its own. A synchronous reset returns the machine to its idle state, and input seen before the reset never contributes to a later hit.

Top module: `dual_seq_onehot_det`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters its idle state and `hit` is 0 after that edge. From then on exactly one state flip-flop is set in every cycle.
- R2: `hit` is 1 after the edge that accepts a bit completing 1,0,1,1,1 as the five most recent bits (oldest first).
- R3: `hit` is 1 after the edge that accepts a bit completing 1,1,0,1,1 as the five most recent bits (oldest first).
- R4: `hit` is 1 after the edge that accepts a bit completing 1,0,1 as the three most recent bits (oldest first).
- R5: Detection continues after a hit, and the bits of one occurrence may be reused by the next. For example, 1,1,0,1,1,0,1,1 gives hits after its fifth and eighth bits, and 1,1,0,1,1,1 gives a hit after its sixth bit.
- R6: `hit` depends only on the state. A change of `din` between clock edges does not change `hit`.
- R7: Bits accepted before a reset never count toward a later hit. A pattern is recognised only after enough bits have been accepted since reset to form it.
- R8: In every other case `hit` is 0. For example, it stays 0 for a run of only 1s, a run of only 0s, and the bit sequence 1,0,0,1,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, one per clock |
| hit | output | 1 | 1 when the accepted history ends in a target pattern |

## Verification
Short directed streams each end on exactly one of the three targets, so a missing or miswired completion term shows up on its own. Overlap streams such as 11011011 and 110111 separate a machine that keeps its partial progress after a hit from one that falls back to idle. Runs of 1s, runs of 0s and near-miss words show whether the machine raises `hit` when it should not. A reset placed in the middle of a partial pattern shows whether bits accepted before the reset are wrongly remembered. A long pseudo-random stream, compared bit by bit against a shift-register model, reaches transitions that the directed streams do not.

// File: rtl/dual_seq_onehot_det.sv
module dual_seq_onehot_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  localparam int NS     = 10;
  localparam int I_IDLE = 0;  // nothing useful seen
  localparam int I_A1   = 1;  // ..1
  localparam int I_A10  = 2;  // ..10
  localparam int I_A101 = 3;  // ..101
  localparam int I_A1011 = 4; // ..1011
  localparam int I_A10111 = 5; // ..10111
  localparam int I_B11  = 6;  // ..11
  localparam int I_B110 = 7;  // ..110
  localparam int I_B1101 = 8; // ..1101
  localparam int I_B11011 = 9; // ..11011
  localparam logic [NS-1:0] IDLE_VEC = NS'(1) << I_IDLE;

  logic [NS-1:0] state;
  logic [NS-1:0] nxt;

  wire zero = ~din;
  wire one  = din;

  assign nxt[I_IDLE]   = zero & (state[I_IDLE] | state[I_A10] | state[I_B110]);
  assign nxt[I_A1]     = one  & state[I_IDLE];
  assign nxt[I_A10]    = zero & (state[I_A1] | state[I_A101] | state[I_B1101]);
  assign nxt[I_A101]   = one  & state[I_A10];
  assign nxt[I_A1011]  = one  & state[I_A101];
  assign nxt[I_A10111] = one  & (state[I_A1011] | state[I_B11011]);
  assign nxt[I_B11]    = one  & (state[I_A1] | state[I_A10111] | state[I_B11]);
  assign nxt[I_B110]   = zero & (state[I_B11] | state[I_A1011] | state[I_A10111] | state[I_B11011]);
  assign nxt[I_B1101]  = one  & state[I_B110];
  assign nxt[I_B11011] = one  & state[I_B1101];

  always_ff @(posedge clk) begin
    if (rst) state <= IDLE_VEC;
    else     state <= nxt;
  end

  assign hit = state[I_A101] | state[I_B1101] | state[I_A10111] | state[I_B11011];

endmodule

module dual_seq_onehot_det_chk (
  input logic        clk,
  input logic        rst,
  input logic        din,
  input logic        hit,
  input logic [9:0]  state,
  input logic        st_idle,
  input logic        st_10,
  input logic        st_1011,
  input logic        st_1101
);

  assert_one_hot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(state) == 1);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st_idle && !hit));

  assert_word_a_R2: assert property (@(posedge clk) disable iff (rst)
    (st_1011 && din) |=> hit);

  assert_word_b_R3: assert property (@(posedge clk) disable iff (rst)
    (st_1101 && din) |=> hit);

  assert_short_R4: assert property (@(posedge clk) disable iff (rst)
    (st_10 && din) |=> hit);

endmodule

bind dual_seq_onehot_det dual_seq_onehot_det_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .state(state),
  .st_idle(state[0]), .st_10(state[2]), .st_1011(state[4]), .st_1101(state[8])
);

// File: tb/sim_dual_seq_onehot_det.sv
module sim_dual_seq_onehot_det;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [4:0] hist = '0;
  int cnt = 0;

  always #2 clk = ~clk;

  dual_seq_onehot_det u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

  function automatic logic expected();
    return ((cnt >= 5) && (hist == 5'b10111 || hist == 5'b11011)) ||
           ((cnt >= 3) && (hist[2:0] == 3'b101));
  endfunction

  task automatic check(input logic exp, input string req);
    compared++;
    if (hit !== exp) begin
      mismatched++;
      $display("FAIL %s: hit=%0b expected=%0b at %0t", req, hit, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string req);
    @(negedge clk);
    rst = 1'b0;
    din = b;
    @(posedge clk);
    hist = {hist[3:0], b};
    if (cnt < 7) cnt++;
    #1;
    check(expected(), req);
  endtask

  task automatic send(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) step(bits[i], req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    @(posedge clk);
    hist = '0;
    cnt = 0;
    #1;
    check(1'b0, "R1");
  endtask

  task automatic t_reset();
    do_reset();
    do_reset();
  endtask

  task automatic t_word_a();
    do_reset();
    send(16'b010111, 6, "R2");
    check(1'b1, "R2");
    send(16'b0, 1, "R2");
  endtask

  task automatic t_word_b();
    do_reset();
    send(16'b0011011, 7, "R3");
    check(1'b1, "R3");
  endtask

  task automatic t_short();
    do_reset();
    send(16'b00101, 5, "R4");
    check(1'b1, "R4");
    send(16'b00, 2, "R4");
  endtask

  task automatic t_overlap();
    do_reset();
    send(16'b11011, 5, "R5");
    check(1'b1, "R5");
    send(16'b011, 3, "R5");
    check(1'b1, "R5");
    do_reset();
    send(16'b110111, 6, "R5");
    check(1'b1, "R5");
    send(16'b10111011, 8, "R5");
    check(1'b1, "R5");
  endtask

  task automatic t_moore();
    do_reset();
    send(16'b0101, 4, "R6");
    @(negedge clk);
    din = 1'b0;
    #0.5;
    check(1'b1, "R6");
    din = 1'b1;
    #0.5;
    check(1'b1, "R6");
    send(16'b00, 2, "R6");
    @(negedge clk);
    din = 1'b1;
    #0.5;
    check(1'b0, "R6");
    din = 1'b0;
    #0.5;
    check(1'b0, "R6");
  endtask

  task automatic t_history();
    do_reset();
    send(16'b10, 2, "R7");
    do_reset();
    send(16'b1, 1, "R7");
    check(1'b0, "R7");
    send(16'b110, 3, "R7");
    do_reset();
    send(16'b11, 2, "R7");
    check(1'b0, "R7");
    send(16'b011, 3, "R7");
    check(1'b1, "R7");
  endtask

  task automatic t_quiet();
    do_reset();
    send(16'b11111111, 8, "R8");
    check(1'b0, "R8");
    send(16'b00000000, 8, "R8");
    check(1'b0, "R8");
    send(16'b10011, 5, "R8");
    check(1'b0, "R8");
    send(16'b1001001, 7, "R8");
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] ^ lfsr[7], "R5");
    end
  endtask

  initial begin
    t_reset();
    t_word_a();
    t_word_b();
    t_short();
    t_overlap();
    t_moore();
    t_history();
    t_quiet();
    t_random();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule